// File: doc/BRIEF.md
# Per-Thread Return Address Stack

This block predicts where a subroutine return will go. It holds one small circular stack of return addresses for each hardware thread. A call pushes its return address onto the stack of the thread that made it. A return pops the newest address from that thread's stack. The predicted target and a valid flag come out combinationally in the same cycle as the pop request.

A single store of 32 address slots is shared among the threads. How it is split depends on the threading mode: one, two or four threads per core. With one or two threads, each active thread owns 16 slots. With four threads, each thread owns 8. Whenever the mode input changes, every stack is emptied.

After a misprediction, the front end can reload one thread's top pointer and entry count from a saved checkpoint. The addresses themselves are not checkpointed.

Top module: `link_stack`

## Requirements
- R1: After reset the registered mode is single-thread and every stack is empty. A pop on any thread gives pop_valid low.
- R2: A pop gives the most recently pushed, not yet popped address of its thread, with pop_valid high, in the same cycle as the pop request. Stacks are last-in first-out.
- R3: The mode encoding is 0 for single-thread, 1 for two-thread, and 2 or 3 for four-thread. Per-thread depth is 16 in modes 0 and 1, and 8 in four-thread mode.
- R4: A push onto a full stack overwrites the oldest entry. After depth+1 pushes, exactly depth pops are valid, newest first.
- R5: A pop on an empty stack gives pop_valid low. pop_tgt then shows the slot under the thread's current top pointer, and that pointer does not move.
- R6: Threads that the current mode does not activate are ignored: only thread 0 in mode 0, threads 0 and 1 in mode 1. Their pushes are dropped and leave the other threads' entries intact. Their pops give pop_valid low and pop_tgt zero.
- R7: In a cycle where the mode input differs from the registered mode, pop_valid is low and pushes are dropped. From the next cycle on, every stack is empty under the new mode.
- R8: A push and a pop on the same thread in one cycle act as a pop followed by a push. The pop returns the old top, and the pushed address becomes the new top.
- R9: A restore loads the thread's top pointer, taken modulo the depth, and its count, limited to the depth. A restore overrides a push or pop on the same thread in that cycle.
- R10: Threads are independent. Pushes, pops and overflow on one thread never change another thread's entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Threading mode: 0 single, 1 two threads, 2/3 four threads |
| push_en | input | 1 | Call seen: push an address |
| push_tid | input | 2 | Thread of the push |
| push_addr | input | AW | Return address to push |
| pop_en | input | 1 | Return seen: pop the stack |
| pop_tid | input | 2 | Thread of the pop |
| pop_tgt | output | AW | Predicted return target |
| pop_valid | output | 1 | Target comes from a live entry |
| rs_en | input | 1 | Restore a thread's pointer state |
| rs_tid | input | 2 | Thread being restored |
| rs_top | input | PW | Checkpointed top pointer |
| rs_cnt | input | PW+1 | Checkpointed entry count |

## Verification
A corrupted top pointer or count shows up at the first pop on the affected thread after the fault. It appears either as the wrong address or as a valid flag that disagrees with the number of pushes, so each check pops right after the stimulus it tests. Wrong slot mapping between threads or modes only shows when two threads share the store. For that reason, overflow and ignored-thread tests are followed by pops on a neighbouring thread. Depth errors appear only at the wrap point, so stacks are filled to depth+1 in each mode family.

// File: rtl/link_stack.sv
`timescale 1ns/1ps
module link_stack #(
  parameter int AW   = 32,
  parameter int DEEP = 16,
  localparam int PW  = $clog2(DEEP),
  localparam int CW  = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          push_en,
  input  logic [1:0]    push_tid,
  input  logic [AW-1:0] push_addr,
  input  logic          pop_en,
  input  logic [1:0]    pop_tid,
  output logic [AW-1:0] pop_tgt,
  output logic          pop_valid,
  input  logic          rs_en,
  input  logic [1:0]    rs_tid,
  input  logic [PW-1:0] rs_top,
  input  logic [CW-1:0] rs_cnt
);
  localparam int SHAL  = DEEP / 2;
  localparam int NSLOT = 2 * DEEP;
  localparam int SW    = $clog2(NSLOT);

  logic [1:0]    mode_q;
  logic [PW-1:0] top_q [4];
  logic [CW-1:0] cnt_q [4];
  logic [PW-1:0] top_n [4];
  logic [CW-1:0] cnt_n [4];
  logic [AW-1:0] mem [NSLOT];

  wire           chg   = mode != mode_q;
  wire           four  = mode_q[1];
  wire [PW-1:0]  pmask = four ? PW'(SHAL - 1) : PW'(DEEP - 1);
  wire [CW-1:0]  psize = four ? CW'(SHAL) : CW'(DEEP);

  function automatic logic act(input logic [1:0] t, input logic [1:0] m);
    return (m == 2'd0) ? (t == 2'd0) : ((m == 2'd1) ? !t[1] : 1'b1);
  endfunction

  function automatic logic [SW-1:0] slot(input logic [1:0] t, input logic [PW-1:0] p,
                                         input logic f);
    return f ? {t, p[PW-2:0]} : {t[0], p};
  endfunction

  wire pop_ok  = act(pop_tid, mode_q);
  wire wr_en   = push_en && act(push_tid, mode_q) && !chg && !(rs_en && rs_tid == push_tid);
  wire [SW-1:0] wr_slot = slot(push_tid, top_n[push_tid], four);

  assign pop_tgt   = pop_ok ? mem[slot(pop_tid, top_q[pop_tid], four)] : '0;
  assign pop_valid = pop_en && pop_ok && !chg && (cnt_q[pop_tid] != '0);

  always_comb begin
    logic dpop, dpush, drs;
    for (int t = 0; t < 4; t++) begin
      top_n[t] = top_q[t];
      cnt_n[t] = cnt_q[t];
      drs   = rs_en && rs_tid == 2'(t);
      dpop  = pop_en  && pop_tid  == 2'(t) && act(2'(t), mode_q) && !drs;
      dpush = push_en && push_tid == 2'(t) && act(2'(t), mode_q) && !drs;
      if (drs) begin
        top_n[t] = rs_top & pmask;
        cnt_n[t] = (rs_cnt > psize) ? psize : rs_cnt;
      end else begin
        if (dpop && cnt_q[t] != '0) begin
          top_n[t] = (top_q[t] - 1'b1) & pmask;
          cnt_n[t] = cnt_q[t] - 1'b1;
        end
        if (dpush) begin
          top_n[t] = (top_n[t] + 1'b1) & pmask;
          cnt_n[t] = (cnt_n[t] == psize) ? psize : cnt_n[t] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      for (int t = 0; t < 4; t++) begin
        top_q[t] <= '0;
        cnt_q[t] <= '0;
      end
    end else if (chg) begin
      mode_q <= mode;
      for (int t = 0; t < 4; t++) begin
        top_q[t] <= '0;
        cnt_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < 4; t++) begin
        top_q[t] <= top_n[t];
        cnt_q[t] <= cnt_n[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_slot] <= push_addr;
    end
  end

  p_lifo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && pop_en && pop_tid == $past(push_tid) && !chg)
      |-> (pop_valid && pop_tgt == $past(push_addr)));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[pop_tid] <= psize);

  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pop_en && pop_ok && !pop_valid && !chg && !rs_en && !push_en)
      |-> (top_q[$past(pop_tid)] == $past(top_q[pop_tid])));

  p_idle_thread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !act(pop_tid, mode_q)) |-> (!pop_valid && pop_tgt == '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chg) |-> !pop_valid);
endmodule

// File: tb/sim_link_stack.sv
`timescale 1ns/1ps
module sim_link_stack;
  localparam int AW = 32;
  localparam int PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic push_en = 0, pop_en = 0, rs_en = 0;
  logic [1:0] push_tid = 0, pop_tid = 0, rs_tid = 0;
  logic [AW-1:0] push_addr = 0;
  logic [PW-1:0] rs_top = 0;
  logic [PW:0] rs_cnt = 0;
  logic [AW-1:0] pop_tgt;
  logic pop_valid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  link_stack #(.AW(AW), .DEEP(16)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .push_en(push_en), .push_tid(push_tid), .push_addr(push_addr),
    .pop_en(pop_en), .pop_tid(pop_tid), .pop_tgt(pop_tgt), .pop_valid(pop_valid),
    .rs_en(rs_en), .rs_tid(rs_tid), .rs_top(rs_top), .rs_cnt(rs_cnt));

  typedef struct packed {
    logic        pu; logic [1:0] pt; logic [31:0] pa;
    logic        po; logic [1:0] ot; logic ev; logic [31:0] et;
  } vec_t;

  // four-thread mode, depth 8
  localparam vec_t TBL [11] = '{
    '{1'b1, 2'd0, 32'hA1, 1'b0, 2'd0, 1'b0, 32'h0},
    '{1'b1, 2'd1, 32'hB1, 1'b0, 2'd0, 1'b0, 32'h0},
    '{1'b1, 2'd0, 32'hA2, 1'b0, 2'd0, 1'b0, 32'h0},
    '{1'b0, 2'd0, 32'h0,  1'b1, 2'd0, 1'b1, 32'hA2},
    '{1'b0, 2'd0, 32'h0,  1'b1, 2'd1, 1'b1, 32'hB1},
    '{1'b0, 2'd0, 32'h0,  1'b1, 2'd1, 1'b0, 32'h0},
    '{1'b1, 2'd0, 32'hA3, 1'b1, 2'd0, 1'b1, 32'hA1},
    '{1'b0, 2'd0, 32'h0,  1'b1, 2'd0, 1'b1, 32'hA3},
    '{1'b0, 2'd0, 32'h0,  1'b1, 2'd0, 1'b0, 32'h0},
    '{1'b1, 2'd2, 32'hC1, 1'b1, 2'd3, 1'b0, 32'h0},
    '{1'b0, 2'd0, 32'h0,  1'b1, 2'd2, 1'b1, 32'hC1}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic op(logic pu, logic [1:0] pt, logic [31:0] pa, logic po, logic [1:0] ot);
    push_en = pu; push_tid = pt; push_addr = pa; pop_en = po; pop_tid = ot;
    #1;
  endtask

  task automatic chk(string tag, logic ev, logic [31:0] et, logic ct);
    checks++;
    if (pop_valid !== ev || (ct && pop_tgt !== et)) begin
      fails++;
      $display("FAIL %s: valid=%0b tgt=%h expected valid=%0b tgt=%h", tag, pop_valid, pop_tgt, ev, et);
    end
  endtask

  task automatic pushn(logic [1:0] t, int n, logic [31:0] b);
    for (int i = 1; i <= n; i++) begin op(1, t, b + 32'(i), 0, 0); tick(); end
  endtask

  task automatic popn(string tag, logic [1:0] t, int n, logic [31:0] b, int top);
    for (int i = 0; i < n; i++) begin
      op(0, 0, 0, 1, t); chk(tag, 1'b1, b + 32'(top - i), 1'b1); tick();
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 4; t++) begin op(0, 0, 0, 1, 2'(t)); chk("R1 reset empty", 0, 0, 0); end
    op(0, 0, 0, 0, 0);
    mode = 2'd2; tick();
    foreach (TBL[i]) begin
      op(TBL[i].pu, TBL[i].pt, TBL[i].pa, TBL[i].po, TBL[i].ot);
      if (TBL[i].po) chk(TBL[i].pu && TBL[i].pt == TBL[i].ot ? "R8 pop-then-push" :
                         (TBL[i].ev ? "R2 lifo" : "R5 empty pop"), TBL[i].ev, TBL[i].et, 1'b1);
      tick();
    end
    // R4 R10: overflow thread 3 (depth 8), thread 1 untouched
    op(1, 1, 32'hD1, 0, 0); tick();
    pushn(3, 9, 32'h300);
    popn("R4 overflow four-thread", 3, 8, 32'h300, 9);
    op(0, 0, 0, 1, 3); chk("R4/R5 empty after wrap", 0, 32'h309, 1); tick();
    op(0, 0, 0, 1, 1); chk("R10 other thread intact", 1, 32'hD1, 1); tick();
    // R7 mode change
    op(1, 0, 32'hE1, 0, 0); tick();
    mode = 2'd1; op(1, 0, 32'hE2, 1, 0); chk("R7 change cycle", 0, 0, 0); tick();
    op(0, 0, 0, 1, 0); chk("R7 cleared", 0, 0, 0); tick();
    // R3 two-thread depth 16
    pushn(1, 17, 32'h100);
    popn("R3 depth16 two-thread", 1, 16, 32'h100, 17);
    op(0, 0, 0, 1, 1); chk("R3 17th pop empty", 0, 0, 0); tick();
    // R6 inactive thread in two-thread mode
    op(1, 0, 32'hF1, 0, 0); tick();
    op(1, 2, 32'hBAD, 0, 0); tick();
    op(0, 0, 0, 1, 2); chk("R6 idle thread pop", 0, 0, 1); tick();
    op(0, 0, 0, 1, 0); chk("R6 active thread intact", 1, 32'hF1, 1); tick();
    // R9 restore
    pushn(0, 3, 32'hC0);
    op(1, 0, 32'hDEAD, 0, 0); rs_en = 1; rs_tid = 0; rs_top = 4'd1; rs_cnt = 5'd1; tick();
    rs_en = 0;
    op(0, 0, 0, 1, 0); chk("R9 restored top", 1, 32'hC1, 1); tick();
    op(0, 0, 0, 1, 0); chk("R9 restored count", 0, 0, 0); tick();
    op(0, 0, 0, 0, 0); rs_en = 1; rs_top = 4'd2; rs_cnt = 5'd31; tick();
    rs_en = 0;
    op(0, 0, 0, 1, 0); chk("R9 clamp count", 1, 32'hC2, 1); tick();
    op(0, 0, 0, 1, 0); chk("R9 clamp count 2", 1, 32'hC1, 1); tick();
    // single-thread mode
    mode = 2'd0; op(0, 0, 0, 0, 0); tick();
    op(1, 1, 32'h99, 0, 0); tick();
    op(0, 0, 0, 1, 1); chk("R6 single-thread idle", 0, 0, 1); tick();
    pushn(0, 17, 32'h200);
    popn("R3 depth16 single-thread", 0, 16, 32'h200, 17);
    op(0, 0, 0, 1, 0); chk("R3 single 17th pop", 0, 0, 0); tick();
    op(0, 0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule